// File: doc/BRIEF.md
# Fixed-Slot Instruction Decoder with Semaphore Gating

This block sits in front of one execution engine and turns a stream of 32-bit words into issued instructions. Every instruction is a 64-byte slot delivered as sixteen words, one word per accepted beat. The first word is a header: opcode, slot length in words, debug command and a software hint. The next two words are a synchronization prefix: a wait mode and index, an update mode and index, and a 32-bit threshold. The remaining thirteen words are payload. The block passes the payload to the engine without looking at it.

The block splits the opcode into an engine class (top three bits) and a base operation (low five bits). It rejects any slot that has the wrong length, an engine class this stream may not carry, a placeholder class that must never execute, or a malformed prefix. A rejected slot sets a sticky error flag and is dropped. An accepted slot waits until its semaphore predicate holds and is then offered on a valid/ready issue port. When the engine reports completion, the semaphore named by the update field can be incremented. Only one instruction is in flight at a time.

The 32-entry semaphore file also takes increments posted by peer engines. Each semaphore is a saturating counter that only grows.

Top module: `slot_seq_decoder`

## Requirements
- R1: `slot_ready` is high while the block is collecting a slot and goes low after exactly SLOT_BYTES/4 (default 16) accepted words. Word k carries slot bytes 4k..4k+3, little-endian, with byte 4k in bits [7:0].
- R2: On issue, `issue_class` = byte0[7:5], `issue_base` = byte0[4:0], `issue_trace` = byte2[1:0], `issue_halt` = byte2[7], `issue_hint` = byte3, and `issue_payload` = words 3..15 in order, with word 3 in bits [31:0]. All of these hold steady while `issue_valid` is high and `issue_ready` is low.
- R3: A slot whose byte1 (length in 4-byte words) is not 16 sets the error flag and is never issued.
- R4: An engine class is legal only when its bit in LEGAL_MASK is set (default 0x4C, so classes 2, 3 and 6). An illegal class, or opcode 0xFF, sets the error flag and the slot is not issued.
- R5: An opcode of class 6 (runtime placeholder) is never issued, even though its mask bit is set. It sets the error flag.
- R6: Wait mode byte4 = 0x04 holds issue until semaphore[byte5] >= T. T is the little-endian 32-bit value in bytes 8..11, or 1 when that value is 0. Wait mode 0x00 issues without any test.
- R7: The following set the error flag without issue: a wait mode other than 0x00 or 0x04, an update mode (byte6) other than 0x00 or 0x13, or an active mode whose index (byte5 or byte7) is 32 or more. An index whose mode is 0x00 is ignored.
- R8: Update mode 0x13 adds one to semaphore[byte7] at the clock edge where `done_valid` ends the in-flight instruction. Update mode 0x00 changes no semaphore.
- R9: Semaphores saturate at 2^SEM_W-1 and never wrap.
- R10: `peer_post_valid` adds one to semaphore[`peer_post_idx`]. A peer post and an own completion to the same semaphore in one cycle both count. An increment becomes visible to the wait test on the following cycle.
- R11: After reset, `slot_ready` = 1, `issue_valid` = 0, `err_flag` = 0 and all semaphores are 0. The error flag stays set until reset, and later valid slots still issue.
- R12: `slot_ready` stays low from the last beat of a slot until `done_valid` ends that slot's execution (or until the slot is dropped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Instruction word offered |
| slot_word | input | 32 | Instruction word, little-endian bytes |
| slot_ready | output | 1 | Block accepts a word |
| issue_valid | output | 1 | Decoded instruction offered to the engine |
| issue_ready | input | 1 | Engine takes the instruction |
| issue_class | output | 3 | Engine class from the opcode |
| issue_base | output | 5 | Base operation from the opcode |
| issue_trace | output | 2 | Trace mode (0 off, 1 start, 2 end, 3 both) |
| issue_halt | output | 1 | Halt enable |
| issue_hint | output | 8 | Software hint byte |
| issue_payload | output | 416 | Payload words 3..15, uninterpreted |
| done_valid | input | 1 | Engine finished the in-flight instruction |
| peer_post_valid | input | 1 | Peer engine semaphore increment |
| peer_post_idx | input | 5 | Semaphore the peer increments |
| err_flag | output | 1 | Sticky malformed or illegal slot flag |

## Verification
The assertions assume that `done_valid` is pulsed only while an issued instruction is in flight. They also assume that `slot_word` is meaningful only when `slot_valid` is high. The bench follows both rules: it raises `done_valid` only after it has seen an issue handshake, and it drives peer posts only as single-cycle pulses on named indices. Wait gates that never open are observed for a bounded window and then cleared with a reset, because a held slot can only be released by a later increment. No completion pulse is ever sent to release one.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

   localparam logic [7:0] MODE_NONE   = 8'h00;
   localparam logic [7:0] WAIT_GE     = 8'h04;
   localparam logic [7:0] UPD_INC     = 8'h13;
   localparam logic [2:0] CLASS_RT    = 3'd6;
   localparam logic [7:0] OPC_INVALID = 8'hFF;
   localparam int         HDR_WORDS   = 3;

   // first word of a slot, least significant byte is the opcode
   typedef struct packed {
      logic [7:0] hint;
      logic [7:0] dbg;
      logic [7:0] len;
      logic [7:0] opcode;
   } slot_hdr_t;

   // second word of a slot
   typedef struct packed {
      logic [7:0] upd_idx;
      logic [7:0] upd_mode;
      logic [7:0] wait_idx;
      logic [7:0] wait_mode;
   } slot_sync_t;

   typedef enum logic [1:0] {
      ST_FETCH,
      ST_CHECK,
      ST_HOLD,
      ST_BUSY
   } seq_state_e;

endpackage

// File: rtl/slot_collect.sv
module slot_collect #(
   parameter int SLOT_WORDS = 16,
   parameter int WORD_W     = 32,
   localparam int BEAT_W    = $clog2(SLOT_WORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         accept_en,
   input  logic                         in_valid,
   input  logic [WORD_W-1:0]            in_word,
   output logic                         in_ready,
   output logic                         last_beat,
   output logic [SLOT_WORDS*WORD_W-1:0] slot_flat
);

   logic [BEAT_W-1:0] beat_q;
   logic [WORD_W-1:0] word_q [SLOT_WORDS];
   logic              take;

   assign in_ready  = accept_en;
   assign take      = in_valid && accept_en;
   assign last_beat = take && (beat_q == BEAT_W'(SLOT_WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (take) begin
         beat_q <= last_beat ? '0 : beat_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOT_WORDS; i++) word_q[i] <= '0;
      end else if (take) begin
         for (int i = 0; i < SLOT_WORDS; i++) begin
            if (beat_q == BEAT_W'(i)) word_q[i] <= in_word;
         end
      end
   end

   generate
      for (genvar g = 0; g < SLOT_WORDS; g++) begin : g_flat
         assign slot_flat[g*WORD_W +: WORD_W] = word_q[g];
      end
   endgenerate

endmodule

// File: rtl/slot_check.sv
module slot_check
   import slot_seq_pkg::*;
#(
   parameter int         SLOT_WORDS = 16,
   parameter int         NUM_SEM    = 32,
   parameter logic [7:0] LEGAL_MASK = 8'h4C
) (
   input  slot_hdr_t  hdr,
   input  slot_sync_t sync,
   output logic       slot_ok
);

   localparam logic [8:0] SEM_LIM = 9'(NUM_SEM);

   logic [2:0] eng_class;
   logic [7:0] class_legal;
   logic       len_bad;
   logic       class_bad;
   logic       rt_seen;
   logic       mode_bad;
   logic       idx_bad;

   assign eng_class = hdr.opcode[7:5];

   generate
      for (genvar c = 0; c < 8; c++) begin : g_legal
         if (LEGAL_MASK[c]) begin : g_on
            assign class_legal[c] = 1'b1;
         end else begin : g_off
            assign class_legal[c] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      len_bad   = hdr.len != 8'(SLOT_WORDS);
      class_bad = !class_legal[eng_class] || (hdr.opcode == OPC_INVALID);
      rt_seen   = eng_class == CLASS_RT;
      mode_bad  = ((sync.wait_mode != MODE_NONE) && (sync.wait_mode != WAIT_GE)) ||
                  ((sync.upd_mode  != MODE_NONE) && (sync.upd_mode  != UPD_INC));
      idx_bad   = ((sync.wait_mode == WAIT_GE) && ({1'b0, sync.wait_idx} >= SEM_LIM)) ||
                  ((sync.upd_mode  == UPD_INC) && ({1'b0, sync.upd_idx}  >= SEM_LIM));
      slot_ok   = !(len_bad || class_bad || rt_seen || mode_bad || idx_bad);
   end

endmodule

// File: rtl/sem_file.sv
module sem_file #(
   parameter int  NUM_SEM = 32,
   parameter int  SEM_W   = 8,
   localparam int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inc_a_valid,
   input  logic [IDX_W-1:0]         inc_a_idx,
   input  logic                     inc_b_valid,
   input  logic [IDX_W-1:0]         inc_b_idx,
   input  logic [IDX_W-1:0]         test_idx,
   input  logic [31:0]              test_thr,
   output logic                     test_pass,
   output logic [NUM_SEM*SEM_W-1:0] sem_flat
);

   localparam logic [SEM_W:0] SEM_MAX = {1'b0, {SEM_W{1'b1}}};

   logic [SEM_W-1:0] sem_arr [NUM_SEM];

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
         logic [1:0]       hits;
         logic [SEM_W:0]   sum;
         logic [SEM_W-1:0] cnt_q;

         assign hits = {1'b0, inc_a_valid && (inc_a_idx == IDX_W'(g))} +
                       {1'b0, inc_b_valid && (inc_b_idx == IDX_W'(g))};
         assign sum  = {1'b0, cnt_q} + (SEM_W+1)'(hits);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (sum > SEM_MAX) begin
               cnt_q <= SEM_MAX[SEM_W-1:0];
            end else begin
               cnt_q <= sum[SEM_W-1:0];
            end
         end

         assign sem_arr[g]                   = cnt_q;
         assign sem_flat[g*SEM_W +: SEM_W]   = cnt_q;
      end
   endgenerate

   assign test_pass = 32'(sem_arr[test_idx]) >= test_thr;

endmodule

// File: rtl/slot_seq_decoder.sv
module slot_seq_decoder
   import slot_seq_pkg::*;
#(
   parameter int         SLOT_BYTES = 64,
   parameter int         NUM_SEM    = 32,
   parameter int         SEM_W      = 8,
   parameter logic [7:0] LEGAL_MASK = 8'h4C,
   localparam int        SLOT_WORDS = SLOT_BYTES / 4,
   localparam int        PAY_WORDS  = SLOT_WORDS - HDR_WORDS,
   localparam int        IDX_W      = $clog2(NUM_SEM)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  slot_valid,
   input  logic [31:0]           slot_word,
   output logic                  slot_ready,
   output logic                  issue_valid,
   input  logic                  issue_ready,
   output logic [2:0]            issue_class,
   output logic [4:0]            issue_base,
   output logic [1:0]            issue_trace,
   output logic                  issue_halt,
   output logic [7:0]            issue_hint,
   output logic [PAY_WORDS*32-1:0] issue_payload,
   input  logic                  done_valid,
   input  logic                  peer_post_valid,
   input  logic [IDX_W-1:0]      peer_post_idx,
   output logic                  err_flag
);

   generate
      if ((SLOT_BYTES % 4) != 0 || SLOT_WORDS < HDR_WORDS + 1) begin : g_bad_slot
         $error("slot_seq_decoder: SLOT_BYTES must be a multiple of 4 with room for a payload");
      end
      if (NUM_SEM < 2 || NUM_SEM > 256 || (1 << IDX_W) != NUM_SEM) begin : g_bad_sem
         $error("slot_seq_decoder: NUM_SEM must be a power of two from 2 to 256");
      end
      if (SEM_W < 1 || SEM_W > 32) begin : g_bad_width
         $error("slot_seq_decoder: SEM_W must lie in 1..32");
      end
   endgenerate

   seq_state_e                  state_q;
   logic                        err_q;
   logic                        accept_en;
   logic                        last_beat;
   logic [SLOT_WORDS*32-1:0]    slot_flat;
   slot_hdr_t                   hdr;
   slot_sync_t                  sync;
   logic [31:0]                 sem_value;
   logic [31:0]                 wait_thr;
   logic                        slot_ok;
   logic                        test_pass;
   logic                        gate_ok;
   logic                        issue_fire;
   logic                        own_inc;
   logic [NUM_SEM*SEM_W-1:0]    sem_flat;

   assign accept_en = state_q == ST_FETCH;

   slot_collect #(
      .SLOT_WORDS (SLOT_WORDS),
      .WORD_W     (32)
   ) collect_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_en (accept_en),
      .in_valid  (slot_valid),
      .in_word   (slot_word),
      .in_ready  (slot_ready),
      .last_beat (last_beat),
      .slot_flat (slot_flat)
   );

   assign hdr       = slot_hdr_t'(slot_flat[31:0]);
   assign sync      = slot_sync_t'(slot_flat[63:32]);
   assign sem_value = slot_flat[95:64];
   assign wait_thr  = (sem_value == 32'd0) ? 32'd1 : sem_value;

   slot_check #(
      .SLOT_WORDS (SLOT_WORDS),
      .NUM_SEM    (NUM_SEM),
      .LEGAL_MASK (LEGAL_MASK)
   ) check_i (
      .hdr     (hdr),
      .sync    (sync),
      .slot_ok (slot_ok)
   );

   assign own_inc = (state_q == ST_BUSY) && done_valid && (sync.upd_mode == UPD_INC);

   sem_file #(
      .NUM_SEM (NUM_SEM),
      .SEM_W   (SEM_W)
   ) sems_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_a_valid (own_inc),
      .inc_a_idx   (sync.upd_idx[IDX_W-1:0]),
      .inc_b_valid (peer_post_valid),
      .inc_b_idx   (peer_post_idx),
      .test_idx    (sync.wait_idx[IDX_W-1:0]),
      .test_thr    (wait_thr),
      .test_pass   (test_pass),
      .sem_flat    (sem_flat)
   );

   assign gate_ok     = (sync.wait_mode != WAIT_GE) || test_pass;
   assign issue_valid = (state_q == ST_HOLD) && gate_ok;
   assign issue_fire  = issue_valid && issue_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_FETCH: if (last_beat) state_q <= ST_CHECK;
            ST_CHECK: begin
               if (slot_ok) begin
                  state_q <= ST_HOLD;
               end else begin
                  state_q <= ST_FETCH;
                  err_q   <= 1'b1;
               end
            end
            ST_HOLD:  if (issue_fire) state_q <= ST_BUSY;
            ST_BUSY:  if (done_valid) state_q <= ST_FETCH;
            default:  state_q <= ST_FETCH;
         endcase
      end
   end

   assign issue_class   = hdr.opcode[7:5];
   assign issue_base    = hdr.opcode[4:0];
   assign issue_trace   = hdr.dbg[1:0];
   assign issue_halt    = hdr.dbg[7];
   assign issue_hint    = hdr.hint;
   assign issue_payload = slot_flat[SLOT_WORDS*32-1 : HDR_WORDS*32];
   assign err_flag      = err_q;

endmodule

// File: rtl/slot_seq_decoder_chk.sv
module slot_seq_decoder_chk #(
   parameter int         PAY_W      = 416,
   parameter int         NUM_SEM    = 32,
   parameter int         SEM_W      = 8,
   parameter logic [7:0] LEGAL_MASK = 8'h4C
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     slot_ready,
   input logic                     issue_valid,
   input logic                     issue_ready,
   input logic [2:0]               issue_class,
   input logic [4:0]               issue_base,
   input logic [PAY_W-1:0]         issue_payload,
   input logic                     err_flag,
   input logic [NUM_SEM*SEM_W-1:0] sem_flat
);

   logic [NUM_SEM*SEM_W-1:0] prev_q;
   logic                     nondec_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sem_flat;
   end

   always_comb begin
      nondec_ok = 1'b1;
      for (int i = 0; i < NUM_SEM; i++) begin
         if (sem_flat[i*SEM_W +: SEM_W] < prev_q[i*SEM_W +: SEM_W]) nondec_ok = 1'b0;
      end
   end

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R5
   no_rt_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_class != 3'd6));

   // R4
   legal_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> LEGAL_MASK[issue_class]);

   // R12
   single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(slot_ready && issue_valid));

   // R2
   issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready) |=>
         (issue_valid && $stable(issue_payload) && $stable(issue_class) && $stable(issue_base)));

   // R9
   sem_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nondec_ok);

endmodule

bind slot_seq_decoder slot_seq_decoder_chk #(
   .PAY_W      (PAY_WORDS*32),
   .NUM_SEM    (NUM_SEM),
   .SEM_W      (SEM_W),
   .LEGAL_MASK (LEGAL_MASK)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .slot_ready    (slot_ready),
   .issue_valid   (issue_valid),
   .issue_ready   (issue_ready),
   .issue_class   (issue_class),
   .issue_base    (issue_base),
   .issue_payload (issue_payload),
   .err_flag      (err_flag),
   .sem_flat      (sem_flat)
);

// File: tb/slot_seq_decoder_tb.sv
module slot_seq_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NWORDS     = 16;
   localparam int PAY_W      = (NWORDS - 3) * 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             slot_valid = 1'b0;
   logic [31:0]      slot_word = '0;
   logic             slot_ready;
   logic             issue_valid;
   logic             issue_ready = 1'b1;
   logic [2:0]       issue_class;
   logic [4:0]       issue_base;
   logic [1:0]       issue_trace;
   logic             issue_halt;
   logic [7:0]       issue_hint;
   logic [PAY_W-1:0] issue_payload;
   logic             done_valid = 1'b0;
   logic             peer_post_valid = 1'b0;
   logic [4:0]       peer_post_idx = '0;
   logic             err_flag;

   int checks = 0;
   int errors = 0;
   logic [31:0] sent [NWORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   slot_seq_decoder dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .slot_valid      (slot_valid),
      .slot_word       (slot_word),
      .slot_ready      (slot_ready),
      .issue_valid     (issue_valid),
      .issue_ready     (issue_ready),
      .issue_class     (issue_class),
      .issue_base      (issue_base),
      .issue_trace     (issue_trace),
      .issue_halt      (issue_halt),
      .issue_hint      (issue_hint),
      .issue_payload   (issue_payload),
      .done_valid      (done_valid),
      .peer_post_valid (peer_post_valid),
      .peer_post_idx   (peer_post_idx),
      .err_flag        (err_flag)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      slot_valid      = 1'b0;
      done_valid      = 1'b0;
      peer_post_valid = 1'b0;
      issue_ready     = 1'b1;
      rst_n           = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_slot(input logic [7:0] op, input logic [7:0] len, input logic [7:0] dbg,
                            input logic [7:0] hint, input logic [7:0] wm, input logic [7:0] wi,
                            input logic [7:0] um, input logic [7:0] ui, input logic [31:0] val,
                            input int seed);
      sent[0] = {hint, dbg, len, op};
      sent[1] = {ui, um, wi, wm};
      sent[2] = val;
      for (int i = 3; i < NWORDS; i++) sent[i] = 32'(seed) * 32'h9E37_79B1 + 32'(i) * 32'h0123_4567;
      for (int i = 0; i < NWORDS; i++) begin
         slot_valid = 1'b1;
         slot_word  = sent[i];
         while (!slot_ready) @(negedge clk);
         @(negedge clk);
      end
      slot_valid = 1'b0;
      chk("R1", "ready after last beat", slot_ready, 0);
   endtask

   task automatic wait_issue(output bit got);
      got = 1'b0;
      for (int c = 0; c < 40; c++) begin
         if (issue_valid) begin
            got = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic check_fields(input string req);
      int bad;
      chk(req, "class", issue_class, sent[0][7:5]);
      chk(req, "base", issue_base, sent[0][4:0]);
      chk(req, "trace", issue_trace, sent[0][17:16]);
      chk(req, "halt", issue_halt, sent[0][23]);
      chk(req, "hint", issue_hint, sent[0][31:24]);
      bad = 0;
      for (int i = 3; i < NWORDS; i++) begin
         if (issue_payload[(i-3)*32 +: 32] !== sent[i]) bad++;
      end
      chk("R1/R2", "payload word mismatches", bad, 0);
   endtask

   // at a negedge with issue_valid high and issue_ready high
   task automatic finish_issue(input bit with_peer, input logic [4:0] pidx);
      @(negedge clk);
      chk("R12", "ready while in flight", slot_ready, 0);
      done_valid = 1'b1;
      if (with_peer) begin
         peer_post_valid = 1'b1;
         peer_post_idx   = pidx;
      end
      @(negedge clk);
      done_valid      = 1'b0;
      peer_post_valid = 1'b0;
      chk("R12", "ready after done", slot_ready, 1);
   endtask

   task automatic expect_issue(input string req);
      bit got;
      wait_issue(got);
      chk(req, "issued", got, 1);
      if (got) begin
         check_fields(req);
         finish_issue(1'b0, 5'd0);
      end
   endtask

   task automatic expect_hold(input int n, input string req);
      int seen;
      seen = 0;
      repeat (n) begin
         if (issue_valid) seen++;
         @(negedge clk);
      end
      chk(req, "issue cycles while held", seen, 0);
   endtask

   task automatic expect_error(input string req);
      expect_hold(10, req);
      chk(req, "err_flag", err_flag, 1);
      chk(req, "ready after drop", slot_ready, 1);
   endtask

   task automatic post(input logic [4:0] idx, input int n);
      repeat (n) begin
         peer_post_valid = 1'b1;
         peer_post_idx   = idx;
         @(negedge clk);
      end
      peer_post_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      bit got;
      do_reset();
      // R11 reset state
      chk("R11", "reset slot_ready", slot_ready, 1);
      chk("R11", "reset issue_valid", issue_valid, 0);
      chk("R11", "reset err_flag", err_flag, 0);

      // R2 sweep of all POOL and ALL class opcodes, no wait
      for (int cls = 2; cls <= 3; cls++) begin
         for (int b = 0; b < 32; b++) begin
            send_slot(8'(cls*32 + b), 8'h10, 8'(((b & 1) << 7) | (b & 3)), 8'(b * 7),
                      8'h00, 8'(b + 40), 8'h00, 8'(b + 50), 32'(b), cls*100 + b);
            expect_issue("R2");
         end
      end
      chk("R2", "no error after legal sweep", err_flag, 0);

      // R2 issue held stable while engine not ready
      issue_ready = 1'b0;
      send_slot(8'h46, 8'h10, 8'h81, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 32'd0, 777);
      wait_issue(got);
      chk("R2", "issued with ready low", got, 1);
      repeat (5) @(negedge clk);
      chk("R2", "valid held", issue_valid, 1);
      check_fields("R2");
      issue_ready = 1'b1;
      finish_issue(1'b0, 5'd0);

      // R6 wait on semaphore 10 with zero threshold
      send_slot(8'h41, 8'h10, 8'h00, 8'h00, 8'h04, 8'd10, 8'h00, 8'h00, 32'd0, 11);
      expect_hold(20, "R6");
      post(5'd10, 1);
      expect_issue("R6");

      // R8 completion increment of semaphore 22
      send_slot(8'h42, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h13, 8'd22, 32'd0, 12);
      expect_issue("R8");
      send_slot(8'h43, 8'h10, 8'h00, 8'h00, 8'h04, 8'd22, 8'h00, 8'h00, 32'd1, 13);
      expect_issue("R8");
      send_slot(8'h44, 8'h10, 8'h00, 8'h00, 8'h04, 8'd22, 8'h00, 8'h00, 32'd2, 14);
      expect_hold(15, "R6");
      post(5'd22, 1);
      expect_issue("R6");
      // R8 update mode none leaves semaphore 23 at zero
      send_slot(8'h45, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd23, 32'd0, 15);
      expect_issue("R8");
      send_slot(8'h47, 8'h10, 8'h00, 8'h00, 8'h04, 8'd23, 8'h00, 8'h00, 32'd0, 16);
      expect_hold(15, "R8");
      post(5'd23, 1);
      expect_issue("R8");

      // R10 own completion and peer post on the same semaphore in one cycle
      send_slot(8'h48, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h13, 8'd3, 32'd0, 17);
      wait_issue(got);
      chk("R10", "issued", got, 1);
      finish_issue(1'b1, 5'd3);
      send_slot(8'h49, 8'h10, 8'h00, 8'h00, 8'h04, 8'd3, 8'h00, 8'h00, 32'd2, 18);
      expect_issue("R10");
      send_slot(8'h4A, 8'h10, 8'h00, 8'h00, 8'h04, 8'd3, 8'h00, 8'h00, 32'd3, 19);
      expect_hold(15, "R10");
      post(5'd3, 1);
      expect_issue("R10");

      // R9 saturation: 300 posts leave semaphore 5 at 255
      post(5'd5, 300);
      send_slot(8'h4B, 8'h10, 8'h00, 8'h00, 8'h04, 8'd5, 8'h00, 8'h00, 32'd255, 20);
      expect_issue("R9");
      send_slot(8'h4C, 8'h10, 8'h00, 8'h00, 8'h04, 8'd5, 8'h00, 8'h00, 32'd256, 21);
      expect_hold(15, "R9");
      chk("R9", "no error on held slot", err_flag, 0);

      // R3 length byte checks
      do_reset();
      send_slot(8'h41, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'd0, 30);
      expect_error("R3");
      do_reset();
      send_slot(8'h41, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'd0, 31);
      expect_error("R3");

      // R4 illegal classes and the invalid opcode
      for (int cls = 0; cls < 8; cls++) begin
         if (cls == 2 || cls == 3 || cls == 6) continue;
         do_reset();
         send_slot(8'(cls*32 + 3), 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'd0, 40 + cls);
         expect_error("R4");
      end
      do_reset();
      send_slot(8'hFF, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'd0, 49);
      expect_error("R4");

      // R5 runtime placeholder class
      do_reset();
      send_slot(8'hC1, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'd0, 50);
      expect_error("R5");
      do_reset();
      send_slot(8'hC8, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 32'd0, 51);
      expect_error("R5");

      // R7 malformed synchronization prefix
      do_reset();
      send_slot(8'h41, 8'h10, 8'h00, 8'h00, 8'h05, 8'd1, 8'h00, 8'h00, 32'd0, 60);
      expect_error("R7");
      do_reset();
      send_slot(8'h41, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'd1, 32'd0, 61);
      expect_error("R7");
      do_reset();
      send_slot(8'h41, 8'h10, 8'h00, 8'h00, 8'h04, 8'd32, 8'h00, 8'h00, 32'd0, 62);
      expect_error("R7");
      do_reset();
      send_slot(8'h41, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h13, 8'd200, 32'd0, 63);
      expect_error("R7");

      // R11 sticky flag, later valid slots still issue
      send_slot(8'h61, 8'h10, 8'h02, 8'h33, 8'h00, 8'd99, 8'h00, 8'd99, 32'd0, 64);
      expect_issue("R11");
      chk("R11", "err_flag still set", err_flag, 1);
      do_reset();
      chk("R11", "err_flag cleared by reset", err_flag, 0);

      finish_run();
   end

endmodule